// File: doc/BRIEF.md
# Instruction Decode and Operand Select Stage

This block is the second stage of a five-stage 32-bit RISC pipeline. Each cycle it takes the instruction word and PC copy latched by fetch, presents three register indices to an external register file, and picks the two ALU operands, the store data word and the forwarded instruction word for stage 3. It registers all four. It also resolves branches in this stage. A small condition evaluator tests the value of the rc register, and the stage hands the next fetch address and a write enable back to fetch.

Operand selection follows the instruction class. PC-relative memory operations pair the PC copy with the long constant. Displacement memory operations pair a base register with the short constant, and base index 0 gives the constant zero instead of a register. Register-form ALU operations pair two registers, and immediate-form ALU operations pair a register with the short constant. Branch-and-link carries the PC copy forward. A stop instruction clears a sticky run flag. A stall input turns this cycle into a bubble for stage 3 and blocks the PC update.

Top module: `dec_stage2`

## Requirements
- R1: While reset is high, and on the first cycle after it, x3_o, y3_o, md3_o and ir3_o read 0 and run_o reads 1.
- R2: Instruction fields are opcode [31:27], ra [26:22], rb [21:17], rc [16:12], short constant [16:0] and long constant [21:0]. Both constants are sign-extended to 32 bits. The register index outputs always show the ra, rb and rc fields.
- R3: For the PC-relative load (opcode 2) and the PC-relative store (opcode 4), the next x3_o is pc2_i and the next y3_o is the sign-extended long constant.
- R4: For the displacement load (opcode 1) and the displacement store (opcode 3), the next x3_o is 0 when rb is 0 and otherwise the rb register value. The next y3_o is the sign-extended short constant.
- R5: For register-form ALU operations (opcodes 16 to 23), the next x3_o is the rb value and the next y3_o is the rc value. For immediate-form ALU operations (opcodes 24 to 30), the next y3_o is the sign-extended short constant instead.
- R6: For branch-and-link (opcode 9), the next x3_o is pc2_i and y3_o is 0. For a plain branch (opcode 8), both are 0. For nop (opcode 0) and stop (opcode 31), x3_o, y3_o and md3_o are all 0.
- R7: For stores (opcodes 3 and 4), the next md3_o is the ra register value. For every other opcode it is 0.
- R8: On every cycle without a stall, the next ir3_o equals ir2_i.
- R9: The condition field [2:0] of a branch selects: 0 never, 1 always, 2 rc equals zero, 3 rc nonzero, 4 rc not negative, 5 rc negative. Codes 6 and 7 mean never.
- R10: pc_next_o is the rb value when a branch (opcode 8 or 9) has a true condition, and pc1_i + 4 otherwise.
- R11: A stop instruction (opcode 31) in a cycle without a stall clears run_o on the next cycle. run_o then stays 0 until reset.
- R12: pc_we_o is 1 exactly when stall_i is 0 and run_o is 1.
- R13: A stall cycle loads 0 (nop) into ir3_o, holds x3_o, y3_o and md3_o, and leaves run_o unchanged, even for a stop instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Stall request from hazard logic |
| ir2_i | input | 32 | Instruction word in stage 2 |
| pc2_i | input | 32 | PC copy carried with the instruction |
| pc1_i | input | 32 | Current fetch PC |
| rf_ra_addr_o | output | 5 | Register file read index, ra field |
| rf_rb_addr_o | output | 5 | Register file read index, rb field |
| rf_rc_addr_o | output | 5 | Register file read index, rc field |
| rf_ra_data_i | input | 32 | Value of register ra |
| rf_rb_data_i | input | 32 | Value of register rb |
| rf_rc_data_i | input | 32 | Value of register rc |
| x3_o | output | 32 | Stage-3 first operand |
| y3_o | output | 32 | Stage-3 second operand |
| md3_o | output | 32 | Stage-3 store data |
| ir3_o | output | 32 | Stage-3 instruction word |
| pc_next_o | output | 32 | Next fetch address |
| pc_we_o | output | 1 | Fetch PC write enable |
| run_o | output | 1 | Run flag |

## Verification
Each register index holds a distinct random value, and register 0 is nonzero. This shows whether an operand came from a register, from the PC copy, from a constant or from the zero substitute for base 0. Constants with the sign bit set and clear test the two sign-extension widths. Branches run every condition code against rc values of zero, negative and positive, which separates the six predicates and the taken and not-taken targets. Random stalls mixed into the instruction stream show the bubble, the held operands and the gated PC write apart from normal forwarding. A stop under stall, then one without stall, then reset, test the sticky run flag.

// File: rtl/dec_pkg.sv
package dec_pkg;
    parameter int XLEN     = 32;
    parameter int REG_AW   = 5;
    parameter int OPC_W    = 5;
    parameter int C1_W     = 22;
    parameter int C2_W     = 17;
    parameter int COND_W   = 3;
    localparam int PC_STEP = XLEN / 8;

    localparam logic [OPC_W-1:0] OP_NOP    = 5'd0;
    localparam logic [OPC_W-1:0] OP_LD     = 5'd1;
    localparam logic [OPC_W-1:0] OP_LDR    = 5'd2;
    localparam logic [OPC_W-1:0] OP_ST     = 5'd3;
    localparam logic [OPC_W-1:0] OP_STR    = 5'd4;
    localparam logic [OPC_W-1:0] OP_BR     = 5'd8;
    localparam logic [OPC_W-1:0] OP_BRL    = 5'd9;
    localparam logic [OPC_W-1:0] OP_ALU_LO = 5'd16;
    localparam logic [OPC_W-1:0] OP_IMM_LO = 5'd24;
    localparam logic [OPC_W-1:0] OP_STOP   = 5'd31;

    typedef enum logic [2:0] {
        CLS_NONE, CLS_LS_REL, CLS_LS_DISP, CLS_BR,
        CLS_BRL, CLS_ALU_REG, CLS_ALU_IMM, CLS_STOP
    } op_class_e;

    typedef enum logic [COND_W-1:0] {
        CND_NEVER, CND_ALWAYS, CND_ZERO, CND_NONZERO, CND_GEZ, CND_LTZ
    } cond_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [REG_AW-1:0] ra;
        logic [REG_AW-1:0] rb;
        logic [REG_AW-1:0] rc;
        logic [11:0]       low;
    } instr_t;

    typedef struct packed {
        logic [XLEN-1:0] x;
        logic [XLEN-1:0] y;
        logic [XLEN-1:0] md;
    } operands_t;

    function automatic op_class_e classify(input logic [OPC_W-1:0] opc);
        op_class_e c;
        if (opc == OP_STOP)                    c = CLS_STOP;
        else if (opc >= OP_IMM_LO)             c = CLS_ALU_IMM;
        else if (opc >= OP_ALU_LO)             c = CLS_ALU_REG;
        else if (opc == OP_LDR || opc == OP_STR) c = CLS_LS_REL;
        else if (opc == OP_LD || opc == OP_ST)   c = CLS_LS_DISP;
        else if (opc == OP_BR)                 c = CLS_BR;
        else if (opc == OP_BRL)                c = CLS_BRL;
        else                                   c = CLS_NONE;
        return c;
    endfunction

    function automatic logic is_store(input logic [OPC_W-1:0] opc);
        return (opc == OP_ST) || (opc == OP_STR);
    endfunction

    function automatic logic [XLEN-1:0] sext_c1(input logic [C1_W-1:0] v);
        return {{(XLEN-C1_W){v[C1_W-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sext_c2(input logic [C2_W-1:0] v);
        return {{(XLEN-C2_W){v[C2_W-1]}}, v};
    endfunction
endpackage

// File: rtl/dec_cond_eval.sv
module dec_cond_eval
    import dec_pkg::*;
(
    input  logic [COND_W-1:0] cond_i,
    input  logic [XLEN-1:0]   value_i,
    output logic              true_o
);
    logic is_zero;
    logic is_neg;

    assign is_zero = (value_i == '0);
    assign is_neg  = value_i[XLEN-1];

    always_comb begin
        case (cond_i)
            CND_ALWAYS:  true_o = 1'b1;
            CND_ZERO:    true_o = is_zero;
            CND_NONZERO: true_o = !is_zero;
            CND_GEZ:     true_o = !is_neg;
            CND_LTZ:     true_o = is_neg;
            default:     true_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dec_operand_sel.sv
module dec_operand_sel
    import dec_pkg::*;
(
    input  op_class_e         cls_i,
    input  logic              store_i,
    input  logic [XLEN-1:0]   pc2_i,
    input  logic [C1_W-1:0]   c1_i,
    input  logic [C2_W-1:0]   c2_i,
    input  logic [REG_AW-1:0] rb_idx_i,
    input  logic [XLEN-1:0]   ra_val_i,
    input  logic [XLEN-1:0]   rb_val_i,
    input  logic [XLEN-1:0]   rc_val_i,
    output operands_t         ops_o
);
    logic [XLEN-1:0] base_val;

    assign base_val = (rb_idx_i == '0) ? '0 : rb_val_i;

    always_comb begin
        ops_o    = '0;
        ops_o.md = store_i ? ra_val_i : '0;
        case (cls_i)
            CLS_LS_REL: begin
                ops_o.x = pc2_i;
                ops_o.y = sext_c1(c1_i);
            end
            CLS_LS_DISP: begin
                ops_o.x = base_val;
                ops_o.y = sext_c2(c2_i);
            end
            CLS_BRL: ops_o.x = pc2_i;
            CLS_ALU_REG: begin
                ops_o.x = rb_val_i;
                ops_o.y = rc_val_i;
            end
            CLS_ALU_IMM: begin
                ops_o.x = rb_val_i;
                ops_o.y = sext_c2(c2_i);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dec_stage2.sv
module dec_stage2
    import dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stall_i,
    input  logic [XLEN-1:0]   ir2_i,
    input  logic [XLEN-1:0]   pc2_i,
    input  logic [XLEN-1:0]   pc1_i,
    output logic [REG_AW-1:0] rf_ra_addr_o,
    output logic [REG_AW-1:0] rf_rb_addr_o,
    output logic [REG_AW-1:0] rf_rc_addr_o,
    input  logic [XLEN-1:0]   rf_ra_data_i,
    input  logic [XLEN-1:0]   rf_rb_data_i,
    input  logic [XLEN-1:0]   rf_rc_data_i,
    output logic [XLEN-1:0]   x3_o,
    output logic [XLEN-1:0]   y3_o,
    output logic [XLEN-1:0]   md3_o,
    output logic [XLEN-1:0]   ir3_o,
    output logic [XLEN-1:0]   pc_next_o,
    output logic              pc_we_o,
    output logic              run_o
);
    instr_t    ins;
    op_class_e cls;
    operands_t ops_next;
    operands_t ops_q;
    logic      cond_true;
    logic      is_branch;
    logic      run_q;

    assign ins          = instr_t'(ir2_i);
    assign cls          = classify(ins.opc);
    assign rf_ra_addr_o = ins.ra;
    assign rf_rb_addr_o = ins.rb;
    assign rf_rc_addr_o = ins.rc;

    dec_operand_sel u_sel (
        .cls_i    (cls),
        .store_i  (is_store(ins.opc)),
        .pc2_i    (pc2_i),
        .c1_i     (ir2_i[C1_W-1:0]),
        .c2_i     (ir2_i[C2_W-1:0]),
        .rb_idx_i (ins.rb),
        .ra_val_i (rf_ra_data_i),
        .rb_val_i (rf_rb_data_i),
        .rc_val_i (rf_rc_data_i),
        .ops_o    (ops_next)
    );

    dec_cond_eval u_cond (
        .cond_i  (ir2_i[COND_W-1:0]),
        .value_i (rf_rc_data_i),
        .true_o  (cond_true)
    );

    assign is_branch = (cls == CLS_BR) || (cls == CLS_BRL);
    assign pc_next_o = (is_branch && cond_true) ? rf_rb_data_i
                                                 : pc1_i + XLEN'(PC_STEP);
    assign pc_we_o   = !stall_i && run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ops_q <= '0;
            ir3_o <= '0;
            run_q <= 1'b1;
        end else if (stall_i) begin
            ir3_o <= '0;
        end else begin
            ops_q <= ops_next;
            ir3_o <= ir2_i;
            if (cls == CLS_STOP) run_q <= 1'b0;
        end
    end

    assign x3_o  = ops_q.x;
    assign y3_o  = ops_q.y;
    assign md3_o = ops_q.md;
    assign run_o = run_q;

    p_ir_forward_r8: assert property (@(posedge clk) disable iff (rst)
        !stall_i |=> ir3_o == $past(ir2_i));
    p_stall_bubble_r13: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> ir3_o == '0);
    p_stall_hold_r13: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> ($stable(x3_o) && $stable(y3_o) && $stable(md3_o) && $stable(run_o)));
    p_stop_clears_r11: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && ir2_i[XLEN-1 -: OPC_W] == OP_STOP) |=> !run_o);
    p_run_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        !run_o |=> !run_o);
    p_target_r10: assert property (@(posedge clk) disable iff (rst)
        (pc_next_o != pc1_i + XLEN'(PC_STEP)) |-> (is_branch && pc_next_o == rf_rb_data_i));
endmodule

// File: tb/dec_stage2_bench.sv
`timescale 1ns/1ps
module dec_stage2_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        stall;
    logic [31:0] ir2, pc2, pc1;
    logic [4:0]  ra_a, rb_a, rc_a;
    logic [31:0] x3, y3, md3, ir3, pc_next;
    logic        pc_we, run;
    logic [31:0] regs [32];

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_x, m_y, m_md, m_ir;
    logic        m_run;

    always #10 clk = ~clk;

    dec_stage2 u_dec_stage2 (
        .clk(clk), .rst(rst), .stall_i(stall), .ir2_i(ir2), .pc2_i(pc2), .pc1_i(pc1),
        .rf_ra_addr_o(ra_a), .rf_rb_addr_o(rb_a), .rf_rc_addr_o(rc_a),
        .rf_ra_data_i(regs[ra_a]), .rf_rb_data_i(regs[rb_a]), .rf_rc_data_i(regs[rc_a]),
        .x3_o(x3), .y3_o(y3), .md3_o(md3), .ir3_o(ir3),
        .pc_next_o(pc_next), .pc_we_o(pc_we), .run_o(run)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [31:0] v, input int w);
        return $signed(v << (32 - w)) >>> (32 - w);
    endfunction

    function automatic logic cond_ok(input logic [2:0] c, input logic [31:0] v);
        case (c)
            3'd1: return 1'b1;
            3'd2: return v == 0;
            3'd3: return v != 0;
            3'd4: return !v[31];
            3'd5: return v[31];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] mk(input int op, input int a, input int b, input int c,
                                       input logic [11:0] low);
        return {op[4:0], a[4:0], b[4:0], c[4:0], low};
    endfunction

    // One cycle: drive at negedge, check combinational outputs, then registered ones
    task automatic step(input logic [31:0] ir, input logic [31:0] p2, input logic [31:0] p1,
                        input logic st);
        int op;
        logic [31:0] ex, ey, emd, rav, rbv, rcv, epc;
        @(negedge clk);
        ir2 = ir; pc2 = p2; pc1 = p1; stall = st;
        op  = int'(ir[31:27]);
        rav = regs[ir[26:22]]; rbv = regs[ir[21:17]]; rcv = regs[ir[16:12]];
        ex = 0; ey = 0;
        emd = (op == 3 || op == 4) ? rav : 32'd0;                 // R7
        if (op == 2 || op == 4) begin ex = p2; ey = sx(ir, 22); end  // R3
        else if (op == 1 || op == 3) begin
            ex = (ir[21:17] == 0) ? 32'd0 : rbv; ey = sx(ir, 17);    // R4
        end
        else if (op == 9) ex = p2;                                 // R6
        else if (op >= 16 && op <= 23) begin ex = rbv; ey = rcv; end // R5
        else if (op >= 24 && op <= 30) begin ex = rbv; ey = sx(ir, 17); end
        epc = ((op == 8 || op == 9) && cond_ok(ir[2:0], rcv)) ? rbv : p1 + 4;
        #1;
        chk("R2 ra index", {27'd0, ra_a}, {27'd0, ir[26:22]});
        chk("R2 rc index", {27'd0, rc_a}, {27'd0, ir[16:12]});
        chk("R10/R9 pc_next", pc_next, epc);
        chk("R12 pc_we", {31'd0, pc_we}, {31'd0, !st && m_run});
        if (st) m_ir = 0;
        else begin
            m_x = ex; m_y = ey; m_md = emd; m_ir = ir;
            if (op == 31) m_run = 0;
        end
        @(negedge clk);
        chk(st ? "R13 x hold" : "R3-5 x", x3, m_x);
        chk(st ? "R13 y hold" : "R3-5 y", y3, m_y);
        chk(st ? "R13 md hold" : "R7 md", md3, m_md);
        chk(st ? "R13 bubble" : "R8 ir", ir3, m_ir);
        chk("R11 run", {31'd0, run}, {31'd0, m_run});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; stall = 0; ir2 = 0; pc2 = 0; pc1 = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        m_x = 0; m_y = 0; m_md = 0; m_ir = 0; m_run = 1;
        chk("R1 x", x3, 0);  chk("R1 y", y3, 0); chk("R1 md", md3, 0);
        chk("R1 ir", ir3, 0); chk("R1 run", {31'd0, run}, 32'd1);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) regs[i] = $urandom;
        regs[0] = 32'h0000_0A5A;
        regs[5] = 0; regs[6] = -32'sd7; regs[7] = 32'd9;
        do_reset();

        // Directed: sign-extension corners and base register 0
        step(mk(2, 1, 0, 0, 12'h000) | 32'h0020_0000, 32'h100, 32'h104, 0); // R3 negative c1
        step(mk(4, 3, 1, 0, 12'h123), 32'h200, 32'h204, 0);                 // R3, R7
        step(mk(1, 2, 0, 0, 12'hFFF) | 32'h0001_0000, 32'h300, 32'h304, 0); // R4 rb=0, negative c2
        step(mk(3, 4, 9, 0, 12'h044), 32'h304, 32'h308, 0);                 // R4 rb!=0, R7
        step(mk(17, 1, 2, 3, 12'h000), 32'h308, 32'h30C, 0);                // R5 register form
        step(mk(25, 1, 2, 3, 12'h800) | 32'h0001_0000, 32'h30C, 32'h310, 0);// R5 immediate form
        step(mk(9, 1, 4, 5, 12'h001), 32'h400, 32'h404, 0);                 // R6 brl always
        step(mk(0, 8, 9, 10, 12'hABC), 32'h404, 32'h408, 0);                // R6 nop
        // R9: every condition code against zero, negative and positive rc
        for (int c = 0; c < 8; c++)
            for (int r = 5; r <= 7; r++)
                step(mk(8, 0, 3, r, {9'd0, c[2:0]}), 32'h500, 32'h504, 0);
        // R13: stall while a store is present
        step(mk(3, 4, 9, 0, 12'h010), 32'h600, 32'h604, 1);

        // Random mix with random stalls (no stop)
        for (int n = 0; n < 400; n++) begin
            int pick;
            int opc;
            pick = $urandom_range(0, 9);
            case (pick)
                0: opc = 0;  1: opc = 1;  2: opc = 2;  3: opc = 3;  4: opc = 4;
                5: opc = 8;  6: opc = 9;
                7: opc = $urandom_range(16, 23);
                default: opc = $urandom_range(24, 30);
            endcase
            step({opc[4:0], 27'($urandom)}, $urandom, $urandom, ($urandom_range(0, 7) == 0));
        end

        // R11/R13: stop under stall keeps running; stop without stall clears run
        step(mk(31, 0, 0, 0, 12'h000), 32'h700, 32'h704, 1);
        step(mk(31, 0, 0, 0, 12'h000), 32'h700, 32'h704, 0);
        step(mk(17, 1, 2, 3, 12'h000), 32'h704, 32'h708, 0);  // R12 pc_we low, R11 sticky
        step(mk(8, 0, 3, 7, 12'h001), 32'h708, 32'h70C, 0);
        do_reset();                                          // R1 run restored
        step(mk(18, 6, 7, 5, 12'h000), 32'h800, 32'h804, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule